// File: doc/BRIEF.md
# Converter Offset and Gain Calibration Sequencer

This block tunes the two 7-bit correction words of a digital-to-analog converter without software help. After a start pulse it runs two searches, one after the other. First it holds the converter at the mid-scale code and adjusts the offset word until an external measurement reads the half-scale target. Then it holds the all-ones code and adjusts the gain word until the measurement reads the full-scale target. The all-zero code is never driven, because the converter output cannot reach 0 V.

Each search starts with one measurement taken with the word at zero. That measurement fixes the direction of correction. After it, the six magnitude bits are resolved by successive approximation, most significant bit first, with one measurement per bit. A measurement that equals the target ends the search at once.

Each measurement travels over two valid/ready channels. On the request channel, `meas_req_valid_o` is raised and held with the code and words frozen until `meas_req_ready_i` is seen high on a clock edge. The result channel then raises `meas_rsp_ready_o` and waits for as long as the measuring side needs. A result is taken only on an edge where both `meas_rsp_valid_i` and `meas_rsp_ready_o` are high. No measurement is requested until the programmed settle count has passed since the last change of code or word.

Top module: `cal_seq`

## Requirements
- R1: After reset the block is idle: `busy_o` and `done_o` low, both words zero, the code at mid-scale (only the top bit set), and neither handshake signal raised.
- R2: A start pulse seen while idle sets `busy_o` on the next cycle, puts the code at mid-scale and clears both words. A start pulse seen while busy has no effect on any output.
- R3: After every change of code or word, `meas_req_valid_o` stays low for exactly SETTLE_CYCLES+1 cycles and then rises. Once raised, it holds with the code and both words unchanged until the cycle in which `meas_req_ready_i` is high.
- R4: `meas_rsp_ready_o` is high only from the cycle after an accepted request until the cycle in which a result is accepted, and it is never high together with `meas_req_valid_o`.
- R5: The offset search uses code 2^(DAC_W-1) and compares against HALF_TARGET. The gain search follows it and uses the all-ones code against FULL_TARGET. The code is never zero.
- R6: Word format: bit 6 set means the correction lowers the output, and bits 5..0 are the magnitude. The first measurement of a search, taken with the word zero, sets bit 6 to 1 if the result is above the target and to 0 if it is below. It also sets trial bit 5.
- R7: Each later measurement judges the current trial bit. The bit is kept if the result is still on the same side of the target as the first one and cleared otherwise. The next lower bit is then set as the new trial. Once bit 0 is judged, the search ends without a further measurement.
- R8: A result equal to the target ends the search at once and leaves the word as it stands. A search therefore takes from one to seven measurements.
- R9: When the gain search ends, `done_o` is high for one cycle and `busy_o` falls in that same cycle. Both words then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a calibration run (taken only while idle) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| dac_code_o | output | DAC_W | Code driven into the converter |
| offset_word_o | output | MAG_W+1 | Offset correction word, sign-magnitude |
| gain_word_o | output | MAG_W+1 | Gain correction word, sign-magnitude |
| meas_req_valid_o | output | 1 | Measurement request valid |
| meas_req_ready_i | input | 1 | Measuring side accepts the request |
| meas_rsp_valid_i | input | 1 | Measurement result valid |
| meas_rsp_ready_o | output | 1 | Block can take a result |
| meas_rsp_data_i | input | ADC_W | Measurement result in ADC counts |

## Verification
The bench holds back request acceptance and result delivery at random. A design that let the code move before a result arrived, or counted the settle time from the wrong edge, would go out of step with the cycle model. The runs cover three kinds of search end: a result equal to the target on the first measurement, a hit on the target midway through the bit search, and errors too large for the six magnitude bits to correct, which must end with every bit kept. A wrong keep/clear rule or a misplaced sign bit shows up as a wrong final word. A start pulse during a run must be ignored, and a design that restarted on it would reset the words part-way.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_REQ    = 2'd2,
    ST_WAIT   = 2'd3
  } cal_state_e;

  typedef enum logic {
    PH_OFS  = 1'b0,
    PH_GAIN = 1'b1
  } cal_phase_e;
endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
  parameter int CNT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic elapsed_o
);
  localparam int CW = (CNT_MAX > 0) ? $clog2(CNT_MAX + 1) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign elapsed_o = (cnt_q == '0);

  // R3
  elapsed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_o && !load_i) |=> elapsed_o);
endmodule

// File: rtl/cal_sar_word.sv
module cal_sar_word #(
  parameter int MAG_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic           apply_i,
  input  logic           eq_i,
  input  logic           above_i,
  output logic [MAG_W:0] word_o,
  output logic           last_o
);
  localparam int IDX_W = $clog2(MAG_W + 1);
  localparam logic [IDX_W-1:0] DIR_IDX = IDX_W'(MAG_W);

  logic [MAG_W:0]   word_q, word_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    if (init_i) begin
      word_d = '0;
      idx_d  = DIR_IDX;
    end else if (apply_i && !eq_i) begin
      if (idx_q == DIR_IDX) begin
        word_d          = '0;
        word_d[MAG_W]   = above_i;
        word_d[MAG_W-1] = 1'b1;
        idx_d           = DIR_IDX - 1'b1;
      end else begin
        if (above_i != word_q[MAG_W]) word_d[idx_q] = 1'b0;
        if (idx_q != '0) begin
          word_d[idx_q - 1'b1] = 1'b1;
          idx_d                = idx_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= DIR_IDX;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
    end
  end

  assign word_o = word_q;
  assign last_o = apply_i && (eq_i || (idx_q == '0));

  // R6
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !(apply_i && idx_q == DIR_IDX)) |=> $stable(word_q[MAG_W]));
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int DAC_W         = 12,
  parameter int ADC_W         = 12,
  parameter int MAG_W         = 6,
  parameter int SETTLE_CYCLES = 8,
  parameter int HALF_TARGET   = 2048,
  parameter int FULL_TARGET   = 4095
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [MAG_W:0]   offset_word_o,
  output logic [MAG_W:0]   gain_word_o,
  output logic             meas_req_valid_o,
  input  logic             meas_req_ready_i,
  input  logic             meas_rsp_valid_i,
  output logic             meas_rsp_ready_o,
  input  logic [ADC_W-1:0] meas_rsp_data_i
);
  localparam logic [DAC_W-1:0] CODE_MID  = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] CODE_FULL = {DAC_W{1'b1}};
  localparam logic [ADC_W-1:0] HALF_T    = ADC_W'(HALF_TARGET);
  localparam logic [ADC_W-1:0] FULL_T    = ADC_W'(FULL_TARGET);

  cal_state_e       state_q;
  cal_phase_e       phase_q;
  logic [DAC_W-1:0] code_q;
  logic             done_q;

  logic             start_ok, rsp_fire, settled;
  logic [ADC_W-1:0] target;
  logic             meas_eq, meas_above, phase_last;
  logic [1:0]       w_init, w_apply, w_last;
  logic [MAG_W:0]   w_word [2];

  assign start_ok   = (state_q == ST_IDLE) && start_i;
  assign rsp_fire   = (state_q == ST_WAIT) && meas_rsp_valid_i;
  assign target     = (phase_q == PH_GAIN) ? FULL_T : HALF_T;
  assign meas_eq    = (meas_rsp_data_i == target);
  assign meas_above = (meas_rsp_data_i > target);
  assign phase_last = (phase_q == PH_GAIN) ? w_last[1] : w_last[0];

  assign w_init[0] = start_ok;
  assign w_init[1] = start_ok || (rsp_fire && phase_q == PH_OFS && w_last[0]);

  cal_settle_timer #(.CNT_MAX(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start_ok || rsp_fire),
    .elapsed_o (settled)
  );

  for (genvar g = 0; g < 2; g++) begin : g_word
    assign w_apply[g] = rsp_fire && (phase_q == cal_phase_e'(g));
    cal_sar_word #(.MAG_W(MAG_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (w_init[g]),
      .apply_i (w_apply[g]),
      .eq_i    (meas_eq),
      .above_i (meas_above),
      .word_o  (w_word[g]),
      .last_o  (w_last[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OFS;
      code_q  <= CODE_MID;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            phase_q <= PH_OFS;
            code_q  <= CODE_MID;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (settled) state_q <= ST_REQ;
        ST_REQ:    if (meas_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (meas_rsp_valid_i) begin
            if (phase_last && phase_q == PH_OFS) begin
              phase_q <= PH_GAIN;
              code_q  <= CODE_FULL;
              state_q <= ST_SETTLE;
            end else if (phase_last) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SETTLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign done_o           = done_q;
  assign dac_code_o       = code_q;
  assign offset_word_o    = w_word[0];
  assign gain_word_o      = w_word[1];
  assign meas_req_valid_o = (state_q == ST_REQ);
  assign meas_rsp_ready_o = (state_q == ST_WAIT);

  // R5
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_code_o != '0);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req_valid_o && !meas_req_ready_i) |=> meas_req_valid_o);
  // R3
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid_o |-> ($stable(dac_code_o) && $stable(offset_word_o) && $stable(gain_word_o)));
  // R4
  hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req_valid_o && meas_rsp_ready_o));
  // R4
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_rsp_ready_o) |-> $past(meas_req_valid_o && meas_req_ready_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $fell(busy_o)));
endmodule

// File: tb/cal_seq_test.sv
module cal_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DAC_W = 12;
  localparam int ADC_W = 13;
  localparam int MAG_W = 6;
  localparam int SET_N = 3;
  localparam int HALF_T = 2048;
  localparam int FULL_T = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_r = 1'b0;
  logic req_ready_r = 1'b0;
  logic rsp_valid_r = 1'b0;
  logic [ADC_W-1:0] rsp_data_r = '0;
  logic busy, done, req_valid, rsp_ready;
  logic [DAC_W-1:0] code;
  logic [MAG_W:0] ofs_w, gain_w;

  int checks = 0, errors = 0;
  int oe_g = 0, ge_g = 0, bp_mode = 0;
  int lfsr = 7, pend = -1, n_req = 0;
  bit armed = 0, req_fired = 0, rsp_fired = 0;

  // behavioural reference
  int m_st = 0, m_cnt = 0, m_ph = 0, m_idx = 6, m_code = 2048, m_done = 0;
  int m_w[2] = '{0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_seq #(.DAC_W(DAC_W), .ADC_W(ADC_W), .MAG_W(MAG_W), .SETTLE_CYCLES(SET_N),
            .HALF_TARGET(HALF_T), .FULL_TARGET(FULL_T)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_r), .busy_o(busy), .done_o(done),
    .dac_code_o(code), .offset_word_o(ofs_w), .gain_word_o(gain_w),
    .meas_req_valid_o(req_valid), .meas_req_ready_i(req_ready_r),
    .meas_rsp_valid_i(rsp_valid_r), .meas_rsp_ready_o(rsp_ready),
    .meas_rsp_data_i(rsp_data_r));

  function automatic int sm(int w);
    return (w >= 64) ? -(w % 64) : w;
  endfunction

  function automatic int adc_model(int c, int ow, int gw);
    int v;
    v = c + oe_g + sm(ow) + (c * (ge_g + sm(gw))) / 2048;
    if (v < 0) v = 0;
    if (v > 8191) v = 8191;
    return v;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    req_fired = req_valid && req_ready_r;
    rsp_fired = rsp_valid_r && rsp_ready;
    if (req_fired) n_req++;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_idx = 6; m_code = 2048; m_done = 0;
      m_w[0] = 0; m_w[1] = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (start_r) begin
             m_ph = 0; m_w[0] = 0; m_w[1] = 0; m_idx = 6; m_code = 2048;
             m_cnt = SET_N; m_st = 1;
           end
        1: if (m_cnt == 0) m_st = 2; else m_cnt--;
        2: if (req_ready_r) m_st = 3;
        default: if (rsp_valid_r) begin
          int meas, w, tgt;
          bit fin, ab;
          meas = int'(rsp_data_r);
          tgt = (m_ph == 1) ? FULL_T : HALF_T;
          ab = meas > tgt;
          w = m_w[m_ph];
          fin = 0;
          if (meas == tgt) fin = 1;
          else if (m_idx == 6) begin
            w = (ab ? 64 : 0) + 32; m_idx = 5;
          end else begin
            if (ab != (w >= 64)) w = w & ~(1 << m_idx);
            if (m_idx == 0) fin = 1;
            else begin m_idx--; w = w | (1 << m_idx); end
          end
          m_w[m_ph] = w;
          if (fin && m_ph == 0) begin
            m_ph = 1; m_code = 4095; m_w[1] = 0; m_idx = 6; m_cnt = SET_N; m_st = 1;
          end else if (fin) begin
            m_done = 1; m_st = 0;
          end else begin
            m_cnt = SET_N; m_st = 1;
          end
        end
      endcase
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      check_eq("R2 busy", int'(busy), int'(m_st != 0));
      check_eq("R9 done", int'(done), m_done);
      check_eq("R5 code", int'(code), m_code);
      check_eq("R7 offset word", int'(ofs_w), m_w[0]);
      check_eq("R7 gain word", int'(gain_w), m_w[1]);
      check_eq("R3 request valid", int'(req_valid), int'(m_st == 2));
      check_eq("R4 result ready", int'(rsp_ready), int'(m_st == 3));
    end
    lfsr = lfsr * 1103515245 + 12345;
    if (rsp_fired) rsp_valid_r = 1'b0;
    if (req_fired) pend = (bp_mode != 0) ? ((lfsr >>> 8) & 3) : 0;
    else if (pend > 0) pend--;
    if (pend == 0) begin
      rsp_valid_r = 1'b1;
      rsp_data_r = ADC_W'(adc_model(int'(code), int'(ofs_w), int'(gain_w)));
      pend = -1;
    end
    req_ready_r = (bp_mode == 0) ? 1'b1 : lfsr[17];
  end

  task automatic run_cal(int oe, int ge, int mode, bit poke);
    oe_g = oe; ge_g = ge; bp_mode = mode;
    @(negedge clk); n_req = 0; start_r = 1'b1;
    @(negedge clk); start_r = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start_r = 1'b1;
      @(negedge clk); start_r = 1'b0;
    end
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    if (!done) check_eq("R9 run completes", 0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 code", int'(code), 2048);
    check_eq("R1 words", int'(ofs_w) + int'(gain_w), 0);
    check_eq("R1 handshake", int'(req_valid) + int'(rsp_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cal(0, 0, 0, 0);
    check_eq("R8 equal on first measurement count", n_req, 2);
    check_eq("R8 words stay zero", int'(ofs_w) + int'(gain_w), 0);

    run_cal(10, 0, 1, 0);
    check_eq("R7 offset word after midway hit", int'(ofs_w), 74);
    check_eq("R6 offset direction lowers", int'(ofs_w[6]), 1);
    check_eq("R8 early end count", n_req, 7);

    run_cal(-37, 5, 1, 1);
    check_eq("R6 offset direction raises", int'(ofs_w[6]), 0);
    check_eq("R7 offset word", int'(ofs_w), 32);
    check_eq("R7 gain word", int'(gain_w), 66);

    run_cal(100, -20, 1, 0);
    check_eq("R7 offset saturates", int'(ofs_w), 127);
    run_cal(-70, 40, 0, 1);
    repeat (5) @(negedge clk);
    check_eq("R9 words hold after done (offset)", int'(ofs_w), m_w[0]);
    check_eq("R9 words hold after done (gain)", int'(gain_w), m_w[1]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule